// File: doc/BRIEF.md
# Bus-Mapped Eight-Pin I/O Port with Edge Interrupts

The block is a bidirectional general-purpose I/O port that sits on a simple processor memory bus. Software reaches seven byte-wide registers through an address, a write strobe with write data and a read strobe with read data. Each pin can be driven from an output latch or left as an input under a per-pin direction bit. A per-pin select bit hands the pin's drive value and drive enable to an alternate peripheral instead.

Every input passes through a two-stage synchronizer. The second stage is the readable pin-state register and the source for edge detection. A pin in the input direction sets its flag on a rising edge or a falling edge, chosen per pin. A single interrupt request line stays high while any flag has its enable bit set, and it drops only when software clears the flag or the enable.

Register offsets on `bus_addr`: 0 pin state (read-only), 1 output latch, 2 direction (1 = output), 3 flags, 4 interrupt enables, 5 edge select (0 = rising, 1 = falling), 6 function select (1 = alternate). Offset 7 reads as 0. Bit n of each register belongs to pin n.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: With function-select bit n at 0, `pin_out[n]` equals output-latch bit n and `pin_oe[n]` equals direction bit n.
- R3: A read of offset 0 returns `pin_in` as it was two clock edges earlier. A write to offset 0 changes nothing readable.
- R4: `bus_rdata` is 0 in every cycle in which `bus_rd` is low.
- R5: The output latch and the other writable registers load `bus_wdata` only on a write to their own offset, and otherwise keep their value.
- R6: With edge-select bit n at 0, a synchronized rising edge on input pin n sets flag n and a falling edge does not. With the bit at 1, the reverse holds.
- R7: A pin whose direction bit is 1 never sets its flag, whatever its input does.
- R8: `irq` is high exactly when some flag bit and the matching enable bit are both 1, and it stays high until software clears that flag or enable.
- R9: Writing offset 3 clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. A 1 never sets a flag.
- R10: When a detected edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R11: With function-select bit n at 1, `pin_out[n]` follows `alt_out[n]` and `pin_oe[n]` follows `alt_oe[n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, 0 while not reading |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad drive values |
| pin_oe | output | 8 | Pad drive enables |
| alt_out | input | 8 | Alternate-function drive values |
| alt_oe | input | 8 | Alternate-function drive enables |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume the pins are low during reset. A pin that is already high at reset release would look like a rising edge to the synchronizer. They also assume that a single strobe selects a single offset in each cycle. The bench holds all pins at 0 through reset. It drives the bus, the pins and the alternate inputs only at falling clock edges, with one strobe at a time. Every pin change is then held for several cycles, so each edge passes through the synchronizer as one clean transition.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int PINS = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [PINS-1:0] bus_wdata,
  input  logic            bus_rd,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  input  logic [PINS-1:0] alt_out,
  input  logic [PINS-1:0] alt_oe,
  output logic            irq
);

  localparam logic [AW-1:0] A_PIN  = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_DIR  = AW'(2);
  localparam logic [AW-1:0] A_FLAG = AW'(3);
  localparam logic [AW-1:0] A_IEN  = AW'(4);
  localparam logic [AW-1:0] A_EDGE = AW'(5);
  localparam logic [AW-1:0] A_FSEL = AW'(6);

  logic [PINS-1:0] sync_a, sync_b, prev_b;
  logic [PINS-1:0] out_q, dir_q, flag_q, ien_q, edge_q, fsel_q;
  logic [PINS-1:0] rise, fall, hit, flag_keep;
  logic            we_out, we_dir, we_flag, we_ien, we_edge, we_fsel;

  assign we_out  = bus_wr && (bus_addr == A_OUT);
  assign we_dir  = bus_wr && (bus_addr == A_DIR);
  assign we_flag = bus_wr && (bus_addr == A_FLAG);
  assign we_ien  = bus_wr && (bus_addr == A_IEN);
  assign we_edge = bus_wr && (bus_addr == A_EDGE);
  assign we_fsel = bus_wr && (bus_addr == A_FSEL);

  assign rise      = sync_b & ~prev_b;
  assign fall      = ~sync_b & prev_b;
  assign hit       = ((rise & ~edge_q) | (fall & edge_q)) & ~dir_q;
  assign flag_keep = we_flag ? (flag_q & bus_wdata) : flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      prev_b <= '0;
      out_q  <= '0;
      dir_q  <= '0;
      flag_q <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      fsel_q <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      prev_b <= sync_b;
      flag_q <= flag_keep | hit;
      if (we_out)  out_q  <= bus_wdata;
      if (we_dir)  dir_q  <= bus_wdata;
      if (we_ien)  ien_q  <= bus_wdata;
      if (we_edge) edge_q <= bus_wdata;
      if (we_fsel) fsel_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_PIN:   bus_rdata = sync_b;
        A_OUT:   bus_rdata = out_q;
        A_DIR:   bus_rdata = dir_q;
        A_FLAG:  bus_rdata = flag_q;
        A_IEN:   bus_rdata = ien_q;
        A_EDGE:  bus_rdata = edge_q;
        A_FSEL:  bus_rdata = fsel_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = (fsel_q & alt_out) | (~fsel_q & out_q);
  assign pin_oe  = (fsel_q & alt_oe)  | (~fsel_q & dir_q);
  assign irq     = |(flag_q & ien_q);

  p_rdata_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_out |=> $stable(out_q));

  p_flag_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_b == prev_b) |=> ((flag_q & ~$past(flag_q)) == '0));

  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !we_flag && !we_ien) |=> irq);

  p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic [7:0] alt_out = '0, alt_oe = '0;
  logic       irq;
  int checks = 0, fails = 0;
  logic [7:0] d;

  gpio_port uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = 3'(a); bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = 3'(a); bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(a, d); chk(d, 8'h00, "R1 reg reset"); end
    chk(pin_oe, 8'h00, "R1 oe"); chk(pin_out, 8'h00, "R1 out"); chk({7'b0, irq}, 8'h00, "R1 irq");
    // R4 quiet bus
    bus_addr = 3'd1; #1 chk(bus_rdata, 8'h00, "R4 no read");

    // R2 R5 R11 sweep of latch, direction and function select
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mv, fs, ao, ae;
      mv = 8'(m); fs = mv ^ 8'h5A; ao = ~mv ^ 8'h33; ae = mv ^ 8'hC6;
      alt_out = ao; alt_oe = ae;
      wr(1, mv); wr(2, ~mv); wr(6, fs);
      wr(0, 8'hFF); wr(7, 8'hFF);
      rd(1, d); chk(d, mv, "R5 out readback");
      rd(2, d); chk(d, ~mv, "R5 dir readback");
      rd(6, d); chk(d, fs, "R5 fsel readback");
      #1;
      chk(pin_out, (fs & ao) | (~fs & mv), "R2 R11 pin_out");
      chk(pin_oe, (fs & ae) | (~fs & ~mv), "R2 R11 pin_oe");
    end
    wr(1, 8'h00); wr(2, 8'h00); wr(6, 8'h00);
    rd(7, d); chk(d, 8'h00, "R5 unused offset");

    // R3 pin state sweep, with writes to the read-only offset
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); pin_in = 8'(v);
      wr(0, ~8'(v));
      rd(0, d); chk(d, 8'(v), "R3 pin state");
    end
    @(negedge clk); pin_in = 8'h00; idle(4);
    wr(3, 8'h00);

    // R6 R8 per-pin edges, both polarities
    for (int i = 0; i < 8; i++) begin
      for (int es = 0; es < 2; es++) begin
        logic [7:0] b;
        b = 8'(1 << i);
        wr(5, es ? 8'hFF : 8'h00); wr(4, b); wr(3, 8'h00);
        @(negedge clk); pin_in = b; idle(4);
        rd(3, d); chk(d, es ? 8'h00 : b, "R6 rising");
        chk({7'b0, irq}, es ? 8'h00 : 8'h01, "R8 irq on rise");
        idle(5); chk({7'b0, irq}, es ? 8'h00 : 8'h01, "R8 irq held");
        wr(3, 8'h00);
        chk({7'b0, irq}, 8'h00, "R8 irq cleared");
        @(negedge clk); pin_in = 8'h00; idle(4);
        rd(3, d); chk(d, es ? b : 8'h00, "R6 falling");
        chk({7'b0, irq}, es ? 8'h01 : 8'h00, "R8 irq on fall");
        wr(4, 8'h00); chk({7'b0, irq}, 8'h00, "R8 enable off");
        wr(3, 8'h00);
      end
    end

    // R7 output-direction pins ignore edges
    wr(5, 8'h0F); wr(2, 8'hFF); wr(4, 8'hFF);
    @(negedge clk); pin_in = 8'hFF; idle(4);
    @(negedge clk); pin_in = 8'h00; idle(4);
    rd(3, d); chk(d, 8'h00, "R7 output pins");
    chk({7'b0, irq}, 8'h00, "R7 irq");
    wr(2, 8'h00);

    // R9 partial clear, ones keep
    wr(5, 8'h00);
    @(negedge clk); pin_in = 8'hFF; idle(4);
    rd(3, d); chk(d, 8'hFF, "R9 all set");
    wr(3, 8'hA5); rd(3, d); chk(d, 8'hA5, "R9 partial clear");
    wr(3, 8'hFF); rd(3, d); chk(d, 8'hA5, "R9 one keeps");
    wr(3, 8'h00); rd(3, d); chk(d, 8'h00, "R9 all clear");
    wr(3, 8'hFF); rd(3, d); chk(d, 8'h00, "R9 one never sets");
    @(negedge clk); pin_in = 8'h00; idle(4);

    // R10 edge and clear in the same cycle
    wr(4, 8'h00);
    @(negedge clk); pin_in = 8'h10;
    @(negedge clk);
    @(negedge clk); bus_addr = 3'd3; bus_wdata = 8'h00; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(3, d); chk(d, 8'h10, "R10 edge wins");
    wr(3, 8'h00); rd(3, d); chk(d, 8'h00, "R10 later clear");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule